// File: doc/BRIEF.md
# Timer Channel with Output Compare and PWM

This block is a 16-bit up-counter with one output channel. A power-of-two prescaler divides the system clock into counter ticks. The counter climbs to a programmable wrap value, returns to zero, and raises an overflow event on that tick. A halt control freezes the counter, and it comes out of reset set. A zero control restarts the counter and the prescaler from a known phase.

The channel compares the counter with a 16-bit compare value. On a match it drives its pin with the selected action: toggle, force low or force high. It also raises a sticky event flag, which can produce an interrupt request.

When overflow-drives-pin is enabled, each overflow forces the pin high. Combined with force-low-on-compare, this gives a free-running PWM output. The wrap value sets the period and the compare value sets the high time, with no software work per cycle. Without that option, software can place each edge by adding a fixed step to the compare value after each event.

Top module: `tmr_pwm_chan`

## Requirements
- R1: After reset the halt bit reads 1, the prescale select reads 0, the wrap value reads 0xFFFF, the compare value reads 0, the count reads 0, and the pin, flag and interrupt request are all 0.
- R2: The halt bit is bit 0 of the control register (address 0). While it is 1 the count does not change. On each clock edge where it was 0 during the preceding cycle, the counter may tick.
- R3: The prescale select is bits 4:2 of the control register. Select value s gives one counter tick every 2^s clock cycles, so select 5 divides by 32. After a zero command, the first tick comes 2^s edges later.
- R4: On a tick with the count equal to the wrap value (address 1), the count becomes 0 and an overflow event occurs. The overflow period is wrap+1 ticks.
- R5: On a tick with the count equal in all 16 bits to the compare value (address 2), the flag is set and the pin takes the action in channel register (address 3) bits 1:0. The codes are 00 no change, 01 toggle, 10 drive low and 11 drive high.
- R6: The flag stays set until a 1 is written to channel register bit 4. If that write lands in the same cycle as a compare match, the flag remains set.
- R7: The interrupt request equals the flag ANDed with the interrupt-enable bit, which is channel register bit 3.
- R8: When overflow-drives-pin (channel register bit 2) is 1, an overflow drives the pin high, and this takes priority over a compare action on the same tick. With the drive-low action, the pin is high for compare+1 ticks of every wrap+1. It stays high throughout when compare is at least wrap.
- R9: Writing 1 to control bit 1 sets the count and the prescaler to 0 at that clock edge. No tick happens in that cycle, and the pin and flag keep their values.
- R10: New wrap and compare values are used from the next tick, with no shadow copy. Adding a step to the compare value, modulo 2^16, produces one further match when the count reaches it, without restarting the counter.
- R11: Reads return: control at address 0 (halt bit 0, select bits 4:2), wrap at 1, compare at 2, channel at 3 (action bits 1:0, overflow-drives-pin bit 2, enable bit 3, flag bit 5, bit 4 reads 0) and the live count at 4. Other addresses read 0, and writes to address 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Combinational read data |
| ch_pin | output | 1 | Channel output pin |
| ch_flag | output | 1 | Sticky channel event flag |
| irq | output | 1 | Channel interrupt request |

## Verification
Directed PWM runs use a small wrap value and several compare values: below wrap, equal to wrap, above wrap, and zero. Together they separate correct high-time counting from an off-by-one and from the wrong winner when overflow and match coincide. A run with the stepped compare value shows that each advance yields exactly one new edge at the expected count. A clear write timed onto a match cycle tells a lost event apart from correct flag priority. Seeded random register writes then mix small prescale ratios, small and full wrap values, zero commands and halts, with the pin, flag, interrupt and every readable register compared each cycle against a reference model.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } pin_act_e;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_WRAP  = 3'd1;
  localparam logic [2:0] A_CMP   = 3'd2;
  localparam logic [2:0] A_CHAN  = 3'd3;
  localparam logic [2:0] A_COUNT = 3'd4;

  localparam int CTRL_HALT    = 0;
  localparam int CTRL_ZERO    = 1;
  localparam int CTRL_SEL_LSB = 2;

  localparam int CHAN_TOV  = 2;
  localparam int CHAN_IE   = 3;
  localparam int CHAN_FCLR = 4;
  localparam int CHAN_FLAG = 5;

endpackage

// File: rtl/tpc_prescaler.sv
module tpc_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             zero,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, mask;
  logic             div_en;

  for (genvar gi = 0; gi < DIV_W; gi++) begin : g_mask
    assign mask[gi] = (gi < int'(sel));
  end

  assign tick = run & ~zero & ((div_q & mask) == mask);

  always_comb begin
    div_en = zero | run;
    if (zero) div_d = '0;
    else      div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end
endmodule

// File: rtl/tpc_counter.sv
module tpc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             zero,
  input  logic [CNT_W-1:0] wrap_at,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign wrap = tick & (cnt_q == wrap_at);
  assign cnt  = cnt_q;

  always_comb begin
    cnt_en = zero | tick;
    if (zero || wrap) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tpc_channel.sv
module tpc_channel
  import tpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  pin_act_e         act,
  input  logic             tov,
  input  logic             ie,
  input  logic             flag_clr,
  output logic             pin,
  output logic             flag,
  output logic             irq
);
  logic hit;
  logic pin_q, pin_d, pin_en;
  logic flag_q, flag_d, flag_en;

  assign hit = tick & (cnt == cmp);

  always_comb begin
    pin_en = (wrap & tov) | hit;
    pin_d  = pin_q;
    if (wrap && tov) begin
      pin_d = 1'b1;
    end else if (hit) begin
      case (act)
        ACT_TOGGLE: pin_d = ~pin_q;
        ACT_CLEAR:  pin_d = 1'b0;
        ACT_SET:    pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_comb begin
    flag_en = hit | flag_clr;
    flag_d  = hit | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (pin_en)  pin_q  <= pin_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign pin  = pin_q;
  assign flag = flag_q;
  assign irq  = flag_q & ie;
endmodule

// File: rtl/tmr_pwm_chan.sv
module tmr_pwm_chan
  import tpc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             ch_pin,
  output logic             ch_flag,
  output logic             irq
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             halt_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] mod_q, cmp_q;
  pin_act_e         act_q;
  logic             tov_q, ie_q;

  logic ctrl_we, wrap_we, cmp_we, chan_we;
  logic zero_cmd, flag_clr;

  always_comb begin
    ctrl_we  = wr_en && (wr_addr == A_CTRL);
    wrap_we  = wr_en && (wr_addr == A_WRAP);
    cmp_we   = wr_en && (wr_addr == A_CMP);
    chan_we  = wr_en && (wr_addr == A_CHAN);
    zero_cmd = ctrl_we && wr_data[CTRL_ZERO];
    flag_clr = chan_we && wr_data[CHAN_FCLR];
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      halt_q <= 1'b1;
      sel_q  <= '0;
    end else if (ctrl_we) begin
      halt_q <= wr_data[CTRL_HALT];
      sel_q  <= wr_data[CTRL_SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)  mod_q <= '1;
    else if (wrap_we) mod_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) cmp_q <= '0;
    else if (cmp_we) cmp_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      act_q <= ACT_NONE;
      tov_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (chan_we) begin
      act_q <= pin_act_e'(wr_data[1:0]);
      tov_q <= wr_data[CHAN_TOV];
      ie_q  <= wr_data[CHAN_IE];
    end
  end

  logic             tick_w, wrap_w;
  logic [CNT_W-1:0] cnt_w;

  tpc_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .run   (~halt_q),
    .zero  (zero_cmd),
    .sel   (sel_q),
    .tick  (tick_w)
  );

  tpc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .tick    (tick_w),
    .zero    (zero_cmd),
    .wrap_at (mod_q),
    .cnt     (cnt_w),
    .wrap    (wrap_w)
  );

  tpc_channel #(.CNT_W(CNT_W)) u_ch (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .tick     (tick_w),
    .wrap     (wrap_w),
    .cnt      (cnt_w),
    .cmp      (cmp_q),
    .act      (act_q),
    .tov      (tov_q),
    .ie       (ie_q),
    .flag_clr (flag_clr),
    .pin      (ch_pin),
    .flag     (ch_flag),
    .irq      (irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[CTRL_HALT]                = halt_q;
        rd_data[CTRL_SEL_LSB +: SEL_W]    = sel_q;
      end
      A_WRAP:  rd_data = mod_q;
      A_CMP:   rd_data = cmp_q;
      A_CHAN: begin
        rd_data[1:0]      = act_q;
        rd_data[CHAN_TOV]  = tov_q;
        rd_data[CHAN_IE]   = ie_q;
        rd_data[CHAN_FLAG] = ch_flag;
      end
      A_COUNT: rd_data = cnt_w;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             zero_wr,
  input logic             fclr_wr,
  input logic             ch_pin,
  input logic             ch_flag,
  input logic             irq,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] mod_v,
  input logic [CNT_W-1:0] cmp_v,
  input logic             tov,
  input logic             halt
);
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !zero_wr) |=> $stable(cnt)); // R2

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == mod_v) |=> (cnt == '0)); // R4

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == cmp_v) |=> ch_flag); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_flag && !fclr_wr) |=> ch_flag); // R6

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ch_flag); // R7

  AST_OVF_DRIVES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == mod_v && tov) |=> ch_pin); // R8

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_wr |=> (cnt == '0)); // R9

  AST_ZERO_KEEPS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    zero_wr |=> $stable(ch_pin)); // R9
endmodule

bind tmr_pwm_chan tpc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .zero_wr (zero_cmd),
  .fclr_wr (flag_clr),
  .ch_pin  (ch_pin),
  .ch_flag (ch_flag),
  .irq     (irq),
  .tick    (tick_w),
  .cnt     (cnt_w),
  .mod_v   (mod_q),
  .cmp_v   (cmp_q),
  .tov     (tov_q),
  .halt    (halt_q)
);

// File: tb/tmr_pwm_chan_tb.sv
`timescale 1ns/1ps
module tmr_pwm_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic [2:0]  rd_addr = 3'd0;
  logic [15:0] rd_data;
  logic        ch_pin, ch_flag, irq;

  int checks = 0;
  int errors = 0;
  logic chk_on = 1'b0;

  always #2 clk = ~clk;

  tmr_pwm_chan u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ch_pin(ch_pin), .ch_flag(ch_flag), .irq(irq)
  );

  // reference model built from the requirements
  logic        m_halt, m_tov, m_ie, m_flag, m_pin;
  logic [2:0]  m_sel;
  logic [1:0]  m_act;
  logic [15:0] m_mod, m_cmp, m_cnt;
  logic [6:0]  m_psc, m_mask;
  logic        m_zero, m_fclr, m_tick, m_ovf, m_hit;

  always_comb begin
    m_zero = wr_en && wr_addr == 3'd0 && wr_data[1];
    m_fclr = wr_en && wr_addr == 3'd3 && wr_data[4];
    m_mask = 7'((8'd1 << m_sel) - 8'd1);
    m_tick = !m_halt && !m_zero && ((m_psc & m_mask) == m_mask);
    m_ovf  = m_tick && (m_cnt == m_mod);
    m_hit  = m_tick && (m_cnt == m_cmp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_halt <= 1'b1; m_sel <= 3'd0; m_mod <= 16'hFFFF; m_cmp <= 16'd0;
      m_act <= 2'd0; m_tov <= 1'b0; m_ie <= 1'b0; m_flag <= 1'b0;
      m_pin <= 1'b0; m_cnt <= 16'd0; m_psc <= 7'd0;
    end else begin
      if (m_zero)       m_psc <= 7'd0;
      else if (!m_halt) m_psc <= m_psc + 7'd1;
      if (m_zero || m_ovf) m_cnt <= 16'd0;
      else if (m_tick)     m_cnt <= m_cnt + 16'd1;
      if (m_ovf && m_tov) m_pin <= 1'b1;
      else if (m_hit) begin
        case (m_act)
          2'd1: m_pin <= ~m_pin;
          2'd2: m_pin <= 1'b0;
          2'd3: m_pin <= 1'b1;
          default: m_pin <= m_pin;
        endcase
      end
      m_flag <= m_hit | (m_flag & ~m_fclr);
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_halt <= wr_data[0]; m_sel <= wr_data[4:2]; end
          3'd1: m_mod <= wr_data;
          3'd2: m_cmp <= wr_data;
          3'd3: begin m_act <= wr_data[1:0]; m_tov <= wr_data[2]; m_ie <= wr_data[3]; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: exp_rd = {11'd0, m_sel, 1'b0, m_halt};
      3'd1: exp_rd = m_mod;
      3'd2: exp_rd = m_cmp;
      3'd3: exp_rd = {10'd0, m_flag, 1'b0, m_ie, m_tov, m_act};
      3'd4: exp_rd = m_cnt;
      default: exp_rd = 16'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      #1;
      check("R5 R8 pin vs model", {15'd0, ch_pin}, {15'd0, m_pin});
      check("R6 flag vs model", {15'd0, ch_flag}, {15'd0, m_flag});
      check("R7 irq vs model", {15'd0, irq}, {15'd0, m_flag & m_ie});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic hi_count(input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      hi += int'(ch_pin);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, c0, nxt;
    logic        p0;
    int          hi, seed;
    seed = $urandom(32'h1a2b);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;

    // R1 reset values and R11 read map
    rd(3'd0, v); check("R1 ctrl", v, 16'h0001);
    rd(3'd1, v); check("R1 wrap", v, 16'hFFFF);
    rd(3'd2, v); check("R1 cmp", v, 16'h0000);
    rd(3'd3, v); check("R1 chan", v, 16'h0000);
    rd(3'd4, v); check("R1 count", v, 16'h0000);
    rd(3'd6, v); check("R11 unmapped", v, 16'h0000);
    check("R1 pin flag irq", {13'd0, ch_pin, ch_flag, irq}, 16'd0);
    wr(3'd4, 16'h1234);
    rd(3'd4, v); check("R11 count write ignored", v, 16'h0000);

    // R2 halt freeze, then run at divide 1
    repeat (10) @(negedge clk);
    rd(3'd4, v); check("R2 halted count", v, 16'd0);
    wr(3'd0, 16'h0000);
    repeat (5) @(negedge clk);
    rd(3'd4, v); check("R2 R3 run div1", v, 16'd5);
    rd(3'd4, c0);
    wr(3'd0, 16'h0001);
    rd(3'd4, v); check("R2 last tick before halt", v, c0 + 16'd1);
    repeat (8) @(negedge clk);
    rd(3'd4, v); check("R2 frozen", v, c0 + 16'd1);

    // R3 divide by 32 from a zero command
    wr(3'd0, 16'h0016);
    repeat (95) @(negedge clk);
    rd(3'd4, v); check("R3 div32 before tick", v, 16'd2);
    @(negedge clk);
    rd(3'd4, v); check("R3 div32 third tick", v, 16'd3);
    rd(3'd0, v); check("R11 ctrl readback", v, 16'h0014);

    // R5 toggle on compare
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd5);
    wr(3'd3, 16'h0011);
    wr(3'd0, 16'h0002);
    #1; p0 = ch_pin;
    wr(3'd3, 16'h0011);
    repeat (4) @(negedge clk);
    #1;
    check("R5 no early toggle", {15'd0, ch_pin}, {15'd0, p0});
    check("R5 no early flag", {15'd0, ch_flag}, 16'd0);
    @(negedge clk);
    #1;
    check("R5 toggled", {15'd0, ch_pin}, {15'd0, ~p0});
    check("R5 flag set", {15'd0, ch_flag}, 16'd1);
    rd(3'd4, v); check("R4 count at match", v, 16'd6);

    // R6 clear colliding with match, R7 irq gating
    wr(3'd1, 16'd3);
    wr(3'd2, 16'd0);
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'h0002);
    wr(3'd3, 16'h0010);
    #1;
    check("R6 collision keeps flag", {15'd0, ch_flag}, 16'd1);
    check("R7 irq masked", {15'd0, irq}, 16'd0);
    wr(3'd3, 16'h0018);
    #1;
    check("R6 flag cleared", {15'd0, ch_flag}, 16'd0);
    check("R7 irq off", {15'd0, irq}, 16'd0);
    repeat (2) @(negedge clk);
    #1; check("R4 no match mid period", {15'd0, ch_flag}, 16'd0);
    @(negedge clk);
    #1;
    check("R4 wrap then match", {15'd0, ch_flag}, 16'd1);
    check("R7 irq raised", {15'd0, irq}, 16'd1);
    rd(3'd3, v); check("R11 chan readback", v, 16'h0028);

    // R8 PWM duty
    wr(3'd1, 16'd9);
    wr(3'd2, 16'd3);
    wr(3'd3, 16'h0006);
    repeat (12) @(negedge clk);
    hi_count(20, hi); check("R8 duty cmp3 wrap9", 16'(hi), 16'd8);
    wr(3'd2, 16'd0);
    repeat (12) @(negedge clk);
    hi_count(20, hi); check("R8 duty cmp0", 16'(hi), 16'd2);
    wr(3'd2, 16'd9);
    repeat (12) @(negedge clk);
    hi_count(20, hi); check("R8 cmp equals wrap", 16'(hi), 16'd20);
    wr(3'd2, 16'd20);
    repeat (12) @(negedge clk);
    hi_count(20, hi); check("R8 cmp above wrap", 16'(hi), 16'd20);

    // R9 zero keeps pin and flag
    wr(3'd1, 16'hFFFF);
    wr(3'd3, 16'h0012);
    wr(3'd2, 16'd2);
    wr(3'd0, 16'h0002);
    repeat (4) @(negedge clk);
    #1;
    check("R5 drive low", {15'd0, ch_pin}, 16'd0);
    wr(3'd0, 16'h0002);
    rd(3'd4, v); check("R9 count zeroed", v, 16'd0);
    check("R9 pin kept", {15'd0, ch_pin}, 16'd0);
    check("R9 flag kept", {15'd0, ch_flag}, 16'd1);

    // R10 stepping the compare value
    wr(3'd3, 16'h0011);
    nxt = 16'd10;
    wr(3'd2, nxt);
    for (int s = 0; s < 4; s++) begin
      #1; p0 = ch_pin;
      for (int w = 0; w < 40 && !ch_flag; w++) begin
        @(negedge clk);
        #1;
      end
      rd(3'd4, v); check("R10 match at stepped compare", v, nxt + 16'd1);
      check("R10 one edge per step", {15'd0, ch_pin}, {15'd0, ~p0});
      nxt = (nxt + 16'd7) & 16'hFFFF;
      wr(3'd2, nxt);
      wr(3'd3, 16'h0011);
    end

    // seeded random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d;
      logic [2:0]  a;
      rd_addr = 3'($urandom % 6);
      #1;
      check("R11 random readback", rd_data, exp_rd(rd_addr));
      wr_en = 1'b0;
      if ($urandom % 4 == 0) begin
        a = 3'($urandom % 5);
        d = 16'($urandom);
        case (a)
          3'd0: d = {11'd0, 1'b0, d[3:1], ($urandom % 8 == 0)};
          3'd1: d = ($urandom % 6 == 0) ? 16'hFFFF : (d & 16'h001F);
          3'd2: d = d & 16'h003F;
          3'd3: d = d & 16'h003F;
          default: ;
        endcase
        wr_en = 1'b1; wr_addr = a; wr_data = d;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    @(negedge clk);
    chk_on = 1'b0;
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule